// File: doc/BRIEF.md
# Byte-Lane Asynchronous Static Memory Model

This block is a synthesizable stand-in for an asynchronous static memory with 16-bit words. It has active-low controls for chip select, write enable and output enable. It also has two active-low byte enables: one for the low byte and one for the high byte. The block decodes these pins on its own for each byte lane. Each lane then drives read data, accepts write data, or stays quiet.

There are no bidirectional pins. The model has a separate write-data input, a read-data output and one drive flag per lane, which a wrapper can turn into pad tristate controls. A standby flag reports when the device is deselected. The storage array is internal, and its depth is set by a parameter so that it stays small in simulation.

The control pins are sampled on a free-running clock. A write is recorded while it is active. The write is committed when the strobe ends, which is when write enable or chip select is released, whichever comes first. Data and lanes are taken from the last sample before the strobe ended. A read of the same address in the window between the strobe ending and the commit edge sees the new data.

Top module: `sram_lane_model`

## Requirements
- R1: Byte enable `lb_n` governs word bits 7..0 and `lane_oe[0]`; byte enable `ub_n` governs bits 15..8 and `lane_oe[1]`.
- R2: `standby` is 1 exactly when `cs_n` is 1 or both byte enables are 1. In standby, `lane_oe` is 2'b00.
- R3: A read occurs when `cs_n`=0, `oe_n`=0 and `we_n`=1. In a read, `lane_oe[i]` is 1 for each lane whose byte enable is 0, and that lane of `rdata` carries the stored byte. A lane that is not driving reads as zero on `rdata`.
- R4: Output-disable mode occurs when `cs_n`=0, `we_n`=1 and `oe_n`=1. In this mode, `lane_oe` is 2'b00 and `rdata` is zero.
- R5: A write happens when `cs_n`=0 and `we_n`=0 with at least one byte enable at 0, whatever the value of `oe_n`. When both byte enables are 1, nothing is stored.
- R6: A write is stored when its strobe ends, whether `we_n` rises or `cs_n` rises first. The stored address, data and lanes are those sampled on the last clock edge before the strobe ended.
- R7: While `cs_n`=0 and `we_n`=0, `lane_oe` is 2'b00 for any value of `oe_n`.
- R8: A lane whose byte enable is 1 during a write keeps its stored value.
- R9: After reset, every word reads as zero.
- R10: A read of the address just written, made after the strobe ends but before the next clock edge, returns the new data on the written lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for the control pins |
| rst_n | input | 1 | Asynchronous active-low reset; clears the array |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| lb_n | input | 1 | Low byte enable (bits 7..0), active low |
| ub_n | input | 1 | High byte enable (bits 15..8), active low |
| addr | input | ADDR_W | Word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data; lanes that are not driving are zero |
| lane_oe | output | 2 | Per-lane drive flag, bit 0 low byte, bit 1 high byte |
| standby | output | 1 | Device deselected |

## Verification
The end of a write and a read of the same word can fall in the same cycle. When the strobe is released, `oe_n` drops in the same interval, so the read is served from the captured write before the commit edge. The bench provokes this after every write that ends on write enable. It compares the forwarded read data with its own model of the array, which was already updated by the byte mask. Writes that end on chip select are then read back after the commit, so that both ways of ending a write are judged against the same model.

// File: rtl/sram_lane_model.sv
module sram_lane_model #(
  parameter int ADDR_W = 4,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              lb_n,
  input  logic              ub_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [2*LANE_W-1:0] wdata,
  output logic [2*LANE_W-1:0] rdata,
  output logic [1:0]        lane_oe,
  output logic              standby
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int WORD_W = 2 * LANE_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [1:0]        be;
  logic              write_act, read_en, flush;
  logic              pend;
  logic [ADDR_W-1:0] p_addr;
  logic [WORD_W-1:0] p_data;
  logic [1:0]        p_be;

  assign be        = ~{ub_n, lb_n};
  assign write_act = !cs_n && !we_n && (be != 2'b00);
  assign read_en   = !cs_n && we_n && !oe_n;
  assign flush     = pend && !write_act;
  assign standby   = cs_n || (lb_n && ub_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend   <= 1'b0;
      p_addr <= '0;
      p_data <= '0;
      p_be   <= '0;
      for (int w = 0; w < DEPTH; w++) mem[w] <= '0;
    end else begin
      if (write_act) begin
        pend   <= 1'b1;
        p_addr <= addr;
        p_data <= wdata;
        p_be   <= be;
      end else begin
        pend <= 1'b0;
      end
      if (flush)
        for (int g = 0; g < 2; g++)
          if (p_be[g]) mem[p_addr][g*LANE_W +: LANE_W] <= p_data[g*LANE_W +: LANE_W];
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic fwd;
    assign fwd        = flush && p_be[g] && (p_addr == addr);
    assign lane_oe[g] = read_en && be[g];
    assign rdata[g*LANE_W +: LANE_W] = !lane_oe[g] ? '0 :
                                       fwd ? p_data[g*LANE_W +: LANE_W] :
                                             mem[addr][g*LANE_W +: LANE_W];
  end

  p_standby_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    standby |-> lane_oe == 2'b00);

  p_write_hiz_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !we_n) |-> lane_oe == 2'b00);

  p_idle_lane_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !lane_oe[1] |-> rdata[WORD_W-1:LANE_W] == '0);

  p_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
    write_act |=> pend);

  p_single_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !pend || write_act);

  p_commit_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && p_be[0]) |=> mem[$past(p_addr)][LANE_W-1:0] == $past(p_data[LANE_W-1:0]));

  p_keep_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !p_be[0]) |=> mem[$past(p_addr)][LANE_W-1:0] == $past(mem[p_addr][LANE_W-1:0]));

  p_keep_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !p_be[1]) |=> mem[$past(p_addr)][WORD_W-1:LANE_W] == $past(mem[p_addr][WORD_W-1:LANE_W]));
endmodule

// File: tb/test_sram_lane_model.sv
module test_sram_lane_model;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, lb_n = 1'b1, ub_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [1:0]  lane_oe;
  logic        standby;

  int checks = 0;
  int fails = 0;
  logic [15:0] model [DEPTH];

  always #4 clk = ~clk;

  sram_lane_model #(.ADDR_W(AW), .LANE_W(8)) i_sram_lane_model (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
    .lb_n(lb_n), .ub_n(ub_n), .addr(addr), .wdata(wdata),
    .rdata(rdata), .lane_oe(lane_oe), .standby(standby));

  function automatic logic [1:0] exp_oe(logic c, logic w, logic o, logic l, logic u);
    return (!c && w && !o) ? ~{u, l} : 2'b00;
  endfunction

  function automatic logic [15:0] exp_rd(logic [1:0] oe, logic [AW-1:0] a);
    return model[a] & {{8{oe[1]}}, {8{oe[0]}}};
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic probe(string req);
    logic [1:0] e;
    #1;
    e = exp_oe(cs_n, we_n, oe_n, lb_n, ub_n);
    chk({req, " standby R2"}, standby, cs_n || (lb_n && ub_n));
    chk({req, " lane_oe"}, lane_oe, e);
    chk({req, " rdata"}, rdata, exp_rd(e, addr));
  endtask

  task automatic go_idle();
    @(negedge clk);
    cs_n = 1; we_n = 1; oe_n = 1; lb_n = 1; ub_n = 1;
  endtask

  task automatic do_read(logic [AW-1:0] a, logic c, logic o, logic l, logic u, string req);
    @(negedge clk);
    addr = a; cs_n = c; we_n = 1; oe_n = o; lb_n = l; ub_n = u;
    probe(req);
  endtask

  task automatic do_write(logic [AW-1:0] a, logic [15:0] d, logic l, logic u,
                          logic o, logic end_cs);
    @(negedge clk);
    addr = a; wdata = ~d; cs_n = 0; we_n = 0; oe_n = o; lb_n = l; ub_n = u;
    #1;
    chk("R7 write keeps lanes quiet", lane_oe, 2'b00);
    @(negedge clk);
    wdata = d;
    @(negedge clk);
    if (!l) model[a][7:0] = d[7:0];
    if (!u) model[a][15:8] = d[15:8];
    if (end_cs) begin
      cs_n = 1;
      probe("R6 end by chip select");
    end else begin
      we_n = 1; oe_n = 0; lb_n = 0; ub_n = 0;
      probe("R10 forwarded read");
    end
    go_idle();
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_0101));
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    rst_n = 1;
    for (int i = 0; i < DEPTH; i++) do_read(i[AW-1:0], 0, 0, 0, 0, "R9 reset contents");
    do_read(0, 1, 0, 0, 0, "R2 deselected");
    do_read(0, 0, 0, 1, 1, "R2 both lanes off");
    do_write(3, 16'hA55A, 0, 0, 1, 0);
    do_read(3, 0, 1, 0, 0, "R4 output disable");
    do_read(3, 0, 0, 0, 1, "R1 low lane only");
    do_read(3, 0, 0, 1, 0, "R1 high lane only");
    do_write(3, 16'h1234, 1, 0, 0, 0);
    do_read(3, 0, 0, 0, 0, "R8 low lane kept");
    do_write(3, 16'hFFEE, 0, 1, 0, 1);
    do_read(3, 0, 0, 0, 0, "R8 high lane kept R6");
    do_write(5, 16'hBEEF, 1, 1, 0, 0);
    do_read(5, 0, 0, 0, 0, "R5 no lanes no store");
    do_write(7, 16'hC0DE, 0, 0, 0, 1);
    do_read(7, 0, 0, 0, 0, "R5 oe ignored R6");
    @(negedge clk);
    addr = 7; cs_n = 0; we_n = 0; oe_n = 0; lb_n = 1; ub_n = 1;
    probe("R7 strobe without lanes");
    go_idle();
    for (int n = 0; n < 400; n++) begin
      logic [AW-1:0] a;
      a = AW'($urandom);
      if ($urandom % 2 == 0)
        do_write(a, 16'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      else
        do_read(a, ($urandom % 4) == 0, 1'($urandom), 1'($urandom), 1'($urandom), "R3 random read");
    end
    for (int i = 0; i < DEPTH; i++) do_read(i[AW-1:0], 0, 0, 0, 0, "R3 final sweep");
    finish_run();
  end
endmodule